// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Replacement

This block sits between a small bank of comparator timers and the interrupt controllers of a system. Each timer delivers a one-clock expiry strobe; the router checks the timer's own enable bit and the global enable bit. It then picks the target interrupt line from the timer's five-bit route field and emits a single-cycle pulse on that line. The pulse goes out twice: once numbered as a legacy ISA line, and once numbered as an I/O APIC input pin, where ISA line 0 lands on pin 2.

A global legacy-replacement flag changes the routing of timers 0 and 1. While it is set, timer 0 is forced onto ISA line 0 and timer 1 onto ISA line 8, whatever their route fields hold. The same flag also controls two older interrupt sources. Its rising edge emits a stop pulse for channel 0 of the legacy interval timer. Its falling edge emits a restart command for that channel. While the flag is set, the real-time-clock interrupt can still be cleared but cannot be raised.

When several timers expire in the same cycle, they are served one per cycle, lowest index first, so that the pulse vector is always one-hot. The block also reports a constant mask of the route targets it advertises as valid.

Top module: `tmr_irq_router`

## Requirements
- R1: Global configuration `gcfg` bit 0 is the global enable and bit 1 is the legacy flag. No interrupt pulse is produced while the global enable is 0, or for a timer whose configuration bit 2 (timer enable) is 0 when it fires.
- R2: Outside legacy mode, a qualified fire of timer i raises `irq_pulse[n]` for exactly one clock, in the cycle after the fire is sampled. Here n is bits 13:9 of that timer's 16-bit configuration word, and timer i's word occupies `tmr_cfg[16*i +: 16]`.
- R3: In legacy mode, timer 0 is sent to line 0 and timer 1 to line 8, regardless of their route fields. Timers 2 and above still use their route fields.
- R4: `apic_pulse` carries the same pulse as `irq_pulse`, except that a pulse for line 0 appears on pin 2.
- R5: When several qualified fires are outstanding, they are delivered one per cycle in increasing timer index. Fires that are not served in a cycle are kept for later cycles. Both pulse vectors are one-hot or zero in every cycle.
- R6: Clearing the global enable discards all fires still waiting for delivery. They are not delivered after the enable returns.
- R7: A 0-to-1 change of the legacy flag produces `pit_stop` high for one clock, in the cycle after the change is sampled.
- R8: A 1-to-0 change of the legacy flag produces `pit_restart` high for one clock, in the cycle after the change is sampled. In that same cycle `pit_mode`=3, `pit_gate`=1 and `pit_count`=0. At all other times those three outputs are 0.
- R9: `rtc_irq` clears on the clock after `rtc_lower`, in every mode, and lowering wins over a simultaneous raise. It sets on the clock after `rtc_raise` only when the legacy flag is 0.
- R10: `route_cap` reads 0x00000C20, advertising lines 5, 10 and 11 as valid route targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gcfg | input | 2 | Global config: bit 0 enable, bit 1 legacy flag |
| tmr_cfg | input | NUM_TMR*16 | Per-timer config words: bit 2 enable, bits 13:9 route |
| tmr_fire | input | NUM_TMR | Per-timer one-clock expiry strobes |
| rtc_raise | input | 1 | Request to assert the RTC interrupt |
| rtc_lower | input | 1 | Request to deassert the RTC interrupt |
| irq_pulse | output | NUM_LINES | One-clock pulse, ISA line numbering |
| apic_pulse | output | NUM_LINES | One-clock pulse, I/O APIC pin numbering |
| pit_stop | output | 1 | Stop legacy interval timer channel 0 |
| pit_restart | output | 1 | Restart legacy interval timer channel 0 |
| pit_mode | output | 3 | Restart mode, valid with pit_restart |
| pit_gate | output | 1 | Restart gate level, valid with pit_restart |
| pit_count | output | 16 | Restart reload count, valid with pit_restart |
| rtc_irq | output | 1 | Gated RTC interrupt level |
| route_cap | output | 32 | Mask of advertised route targets |

## Verification
Every output of this block is registered once. A fire strobe, a legacy-flag edge or an RTC request that is sampled at one rising edge therefore shows its result in the clock period that follows that edge. A fire that loses arbitration shows up one further period later for each lower-indexed timer served ahead of it. The bench changes inputs on the falling edge and advances a behavioural model by one step from those inputs. It then waits through the next rising edge and compares every output on the falling edge after it, so each result is checked in exactly the period where it is due.

// File: rtl/tmr_router_pkg.sv
package tmr_router_pkg;
  localparam int CFG_W          = 16;
  localparam int EN_BIT         = 2;
  localparam int ROUTE_LO       = 9;
  localparam int ROUTE_W        = 5;
  localparam int GCFG_EN        = 0;
  localparam int GCFG_LEG       = 1;
  localparam int LEG_LINE_T0    = 0;
  localparam int LEG_LINE_T1    = 8;
  localparam int APIC_SRC_LINE  = 0;
  localparam int APIC_DST_PIN   = 2;
  localparam int PIT_RST_MODE   = 3;

  typedef struct packed {
    logic [2:0]  mode;
    logic        gate;
    logic [15:0] count;
  } pit_cmd_t;
endpackage

// File: rtl/tmr_arbiter.sv
module tmr_arbiter #(
  parameter int NUM_TMR = 3,
  localparam int IDX_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_en,
  input  logic [NUM_TMR-1:0] fire_ok,
  output logic               gnt_vld,
  output logic [IDX_W-1:0]   gnt_idx
);
  logic [NUM_TMR-1:0] pend;
  logic [NUM_TMR-1:0] req;
  logic [NUM_TMR-1:0] gnt_oh;

  always_comb begin
    req     = glb_en ? (pend | fire_ok) : '0;
    gnt_oh  = req & (~req + {{(NUM_TMR-1){1'b0}}, 1'b1});
    gnt_vld = |req;
    gnt_idx = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (gnt_oh[i]) gnt_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= req & ~gnt_oh;
  end

  AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> (pend == '0)); // R6
  AST_GNT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |=> !pend[$past(gnt_idx)]); // R5
endmodule

// File: rtl/tmr_line_decode.sv
module tmr_line_decode
  import tmr_router_pkg::*;
#(
  parameter int NUM_TMR   = 3,
  parameter int NUM_LINES = 32,
  localparam int IDX_W    = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       gnt_vld,
  input  logic [IDX_W-1:0]           gnt_idx,
  input  logic                       legacy,
  input  logic [NUM_TMR*ROUTE_W-1:0] route_flat,
  output logic [NUM_LINES-1:0]       irq_q,
  output logic [NUM_LINES-1:0]       apic_q
);
  logic [LINE_W-1:0]    line_sel;
  logic [LINE_W-1:0]    apic_sel;
  logic [NUM_LINES-1:0] irq_d;
  logic [NUM_LINES-1:0] apic_d;

  always_comb begin
    line_sel = LINE_W'(route_flat[gnt_idx*ROUTE_W +: ROUTE_W]);
    if (legacy && gnt_idx == IDX_W'(0))      line_sel = LINE_W'(LEG_LINE_T0);
    else if (legacy && gnt_idx == IDX_W'(1)) line_sel = LINE_W'(LEG_LINE_T1);
    apic_sel = (line_sel == LINE_W'(APIC_SRC_LINE)) ? LINE_W'(APIC_DST_PIN) : line_sel;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign irq_d[g]  = gnt_vld && (line_sel == LINE_W'(g));
    assign apic_d[g] = gnt_vld && (apic_sel == LINE_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= '0;
      apic_q <= '0;
    end else begin
      irq_q  <= irq_d;
      apic_q <= apic_d;
    end
  end

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_q)); // R5
  AST_APIC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(apic_q)); // R5
  AST_APIC_REMAP: assert property (@(posedge clk) disable iff (rst)
    irq_q[APIC_SRC_LINE] |-> (apic_q[APIC_DST_PIN] && !apic_q[APIC_SRC_LINE])); // R4
endmodule

// File: rtl/tmr_legacy_ctl.sv
module tmr_legacy_ctl
  import tmr_router_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     legacy,
  input  logic     rtc_raise,
  input  logic     rtc_lower,
  output logic     pit_stop,
  output logic     pit_start,
  output pit_cmd_t pit_cmd,
  output logic     rtc_irq
);
  logic     leg_q;
  pit_cmd_t restart_cmd;

  assign restart_cmd = '{mode: 3'(PIT_RST_MODE), gate: 1'b1, count: 16'd0};

  always_ff @(posedge clk) begin
    if (rst) begin
      leg_q     <= 1'b0;
      pit_stop  <= 1'b0;
      pit_start <= 1'b0;
      pit_cmd   <= '0;
      rtc_irq   <= 1'b0;
    end else begin
      leg_q     <= legacy;
      pit_stop  <= legacy & ~leg_q;
      pit_start <= ~legacy & leg_q;
      pit_cmd   <= (~legacy & leg_q) ? restart_cmd : '0;
      if (rtc_lower)                rtc_irq <= 1'b0;
      else if (rtc_raise && !legacy) rtc_irq <= 1'b1;
    end
  end

  AST_STOP_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(legacy) |=> pit_stop); // R7
  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(legacy) |=> (pit_start && pit_cmd.mode == 3'(PIT_RST_MODE) && pit_cmd.gate)); // R8
  AST_STOP_START_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pit_stop && pit_start)); // R8
  AST_RTC_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (legacy && !rtc_irq) |=> !rtc_irq); // R9
  AST_RTC_LOWER: assert property (@(posedge clk) disable iff (rst)
    rtc_lower |=> !rtc_irq); // R9
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import tmr_router_pkg::*;
#(
  parameter int          NUM_TMR   = 3,
  parameter int          NUM_LINES = 32,
  parameter logic [31:0] ROUTE_CAP = 32'h0000_0C20,
  localparam int         IDX_W     = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               gcfg,
  input  logic [NUM_TMR*CFG_W-1:0] tmr_cfg,
  input  logic [NUM_TMR-1:0]       tmr_fire,
  input  logic                     rtc_raise,
  input  logic                     rtc_lower,
  output logic [NUM_LINES-1:0]     irq_pulse,
  output logic [NUM_LINES-1:0]     apic_pulse,
  output logic                     pit_stop,
  output logic                     pit_restart,
  output logic [2:0]               pit_mode,
  output logic                     pit_gate,
  output logic [15:0]              pit_count,
  output logic                     rtc_irq,
  output logic [31:0]              route_cap
);
  logic [NUM_TMR-1:0]         fire_ok;
  logic [NUM_TMR*ROUTE_W-1:0] route_flat;
  logic                       gnt_vld;
  logic [IDX_W-1:0]           gnt_idx;
  pit_cmd_t                   pit_cmd;
  logic                       unused_cfg_bits;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign fire_ok[t] = tmr_fire[t] & tmr_cfg[t*CFG_W + EN_BIT];
    assign route_flat[t*ROUTE_W +: ROUTE_W] = tmr_cfg[t*CFG_W + ROUTE_LO +: ROUTE_W];
  end
  assign unused_cfg_bits = ^tmr_cfg;

  tmr_arbiter #(.NUM_TMR(NUM_TMR)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .glb_en  (gcfg[GCFG_EN]),
    .fire_ok (fire_ok),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  tmr_line_decode #(.NUM_TMR(NUM_TMR), .NUM_LINES(NUM_LINES)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .gnt_vld    (gnt_vld),
    .gnt_idx    (gnt_idx),
    .legacy     (gcfg[GCFG_LEG]),
    .route_flat (route_flat),
    .irq_q      (irq_pulse),
    .apic_q     (apic_pulse)
  );

  tmr_legacy_ctl u_leg (
    .clk       (clk),
    .rst       (rst),
    .legacy    (gcfg[GCFG_LEG]),
    .rtc_raise (rtc_raise),
    .rtc_lower (rtc_lower),
    .pit_stop  (pit_stop),
    .pit_start (pit_restart),
    .pit_cmd   (pit_cmd),
    .rtc_irq   (rtc_irq)
  );

  assign pit_mode  = pit_cmd.mode;
  assign pit_gate  = pit_cmd.gate;
  assign pit_count = pit_cmd.count;
  assign route_cap = ROUTE_CAP;

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !gcfg[GCFG_EN] |=> (irq_pulse == '0)); // R1
  AST_LEGACY_T0: assert property (@(posedge clk) disable iff (rst)
    (gcfg == 2'b11 && fire_ok[0]) |=> irq_pulse[LEG_LINE_T0]); // R3
endmodule

// File: tb/tb_tmr_irq_router.sv
module tb_tmr_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  gcfg = '0;
  logic [NT*16-1:0] tmr_cfg = '0;
  logic [NT-1:0] tmr_fire = '0;
  logic        rtc_raise = 1'b0, rtc_lower = 1'b0;
  logic [31:0] irq_pulse, apic_pulse, route_cap;
  logic        pit_stop, pit_restart, pit_gate, rtc_irq;
  logic [2:0]  pit_mode;
  logic [15:0] pit_count;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  bit m_pend [NT];
  bit m_leg_prev, m_rtc;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_router dut (
    .clk(clk), .rst(rst), .gcfg(gcfg), .tmr_cfg(tmr_cfg), .tmr_fire(tmr_fire),
    .rtc_raise(rtc_raise), .rtc_lower(rtc_lower), .irq_pulse(irq_pulse),
    .apic_pulse(apic_pulse), .pit_stop(pit_stop), .pit_restart(pit_restart),
    .pit_mode(pit_mode), .pit_gate(pit_gate), .pit_count(pit_count),
    .rtc_irq(rtc_irq), .route_cap(route_cap)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic step();
    logic [31:0] e_irq = '0, e_apic = '0;
    bit e_stop = 0, e_start = 0;
    int win = -1, line;
    if (rst) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      m_leg_prev = 0;
      m_rtc = 0;
    end else begin
      if (!gcfg[0]) begin
        foreach (m_pend[i]) m_pend[i] = 0;
      end else begin
        for (int i = 0; i < NT; i++)
          if (tmr_fire[i] && tmr_cfg[i*16+2]) m_pend[i] = 1;
      end
      for (int i = 0; i < NT; i++)
        if (m_pend[i] && win < 0) win = i;
      if (win >= 0) begin
        if (gcfg[1] && win == 0)      line = 0;
        else if (gcfg[1] && win == 1) line = 8;
        else                          line = int'(tmr_cfg[win*16+9 +: 5]);
        e_irq  = 32'd1 << line;
        e_apic = 32'd1 << ((line == 0) ? 2 : line);
        m_pend[win] = 0;
      end
      e_stop  = gcfg[1] && !m_leg_prev;
      e_start = !gcfg[1] && m_leg_prev;
      m_leg_prev = gcfg[1];
      if (rtc_lower)                 m_rtc = 0;
      else if (rtc_raise && !gcfg[1]) m_rtc = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, irq_pulse, e_irq);
    chk("R4", apic_pulse, e_apic);
    chk("R7", 32'(pit_stop), 32'(e_stop));
    chk("R8", 32'(pit_restart), 32'(e_start));
    chk("R8", {pit_mode, pit_gate, pit_count}, e_start ? {3'd3, 1'b1, 16'd0} : 32'd0);
    chk("R9", 32'(rtc_irq), 32'(m_rtc));
    chk("R10", route_cap, 32'h0000_0C20);
  endtask

  task automatic set_cfg(int i, bit en, int route);
    tmr_cfg[i*16 +: 16] = (16'(route) << 9) | (16'(en) << 2);
  endtask

  task automatic fire(logic [NT-1:0] m);
    tmr_fire = m;
    step();
    tmr_fire = '0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    idle(2);                                   // reset state
    rst = 1'b0;
    set_cfg(0, 1, 5); set_cfg(1, 1, 7); set_cfg(2, 1, 31);
    // R1: global enable off, and timer enable off
    gcfg = 2'b00; fire(3'b001); idle(1);
    gcfg = 2'b01; set_cfg(0, 0, 5); fire(3'b001); idle(1);
    set_cfg(0, 1, 5);
    // R2: programmable routes
    cur_req = "R2";
    fire(3'b001); idle(1);
    fire(3'b100); idle(1);
    set_cfg(1, 1, 0); fire(3'b010); idle(1);   // route to 0 -> apic pin 2
    set_cfg(1, 1, 7);
    // R3: legacy routing plus pit stop (R7)
    cur_req = "R3";
    gcfg = 2'b11; step();
    fire(3'b001); idle(1);
    fire(3'b010); idle(1);
    set_cfg(2, 1, 11); fire(3'b100); idle(1);
    // R5: simultaneous fires, in legacy and then programmable mode
    cur_req = "R5";
    fire(3'b111); idle(3);
    gcfg = 2'b01; step();                       // R8 restart
    fire(3'b111); fire(3'b001); idle(3);
    // R6: pending dropped on global disable
    cur_req = "R6";
    fire(3'b111); gcfg = 2'b00; idle(2);
    gcfg = 2'b01; idle(3);
    // R7 / R8: legacy toggles with timers idle
    cur_req = "R7";
    gcfg = 2'b11; idle(2); gcfg = 2'b01; idle(2);
    gcfg = 2'b10; idle(1); gcfg = 2'b00; idle(1);
    // R9: RTC gating
    cur_req = "R9";
    gcfg = 2'b01;
    rtc_raise = 1; step(); rtc_raise = 0; idle(1);
    rtc_lower = 1; step(); rtc_lower = 0;
    gcfg = 2'b11; rtc_raise = 1; step(); rtc_raise = 0; idle(1);
    gcfg = 2'b01; rtc_raise = 1; step(); rtc_raise = 0;
    gcfg = 2'b11; rtc_lower = 1; step(); rtc_lower = 0;
    gcfg = 2'b01; rtc_raise = 1; rtc_lower = 1; step();
    rtc_raise = 0; rtc_lower = 0; idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule